// File: doc/BRIEF.md
# Reset and Configuration-Load Sequencer

This block turns an external hardware reset pin into the device's internal reset events and then steps through the loading of configuration from a serial EEPROM. The pin counts only while power-good is high, and only when it stays asserted for a programmable number of consecutive clock cycles. Shorter or unpowered assertions are dropped.

A qualified hardware reset produces a one-cycle hardware-reset pulse and restarts the sequence. The sequencer then waits for the pin to be released. It next issues a one-cycle EEPROM-register reset pulse, which clears every register the EEPROM can program. The cycle after that it requests the EEPROM load. When the load reports completion with a failed CRC, the sequencer issues the EEPROM-register reset once more, so the device is left in a clean default state.

The block also holds the bus width mode bit. Hardware reset clears it, which leaves the host interface in 16-bit mode. A 32-bit host write to the data-port offset (default 10h) sets it. The EEPROM serial protocol itself is handled elsewhere; this block only starts a load and consumes its done and CRC status.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `hrst_pulse`, `eerst_pulse` and `ld_start` are 0 and `dword_io` is 0.
- R2: If `rst_pin` and `pwr_good` are both sampled high on MIN_PW consecutive rising edges, `hrst_pulse` is 1 for exactly the one cycle that follows the MIN_PW-th of those edges. It is not repeated while the pin stays asserted.
- R3: An assertion of `rst_pin` shorter than MIN_PW cycles, or an assertion of any length while `pwr_good` is low, produces no `hrst_pulse`, no `eerst_pulse` and no `ld_start`.
- R4: A drop of `pwr_good` during an assertion restarts the width count. MIN_PW fresh consecutive qualified cycles are then needed for the pulse.
- R5: After a qualified hardware reset, the first edge that samples `rst_pin` low makes `eerst_pulse` 1 for one cycle. `ld_start` is 1 for the one cycle right after that. `ld_start` is never 1 while `eerst_pulse` is 1.
- R6: When `ld_done` is sampled high while a load is pending: with `ld_crc_ok`=1 nothing more is pulsed; with `ld_crc_ok`=0, `eerst_pulse` is 1 for the one following cycle and `ld_start` stays 0.
- R7: `dword_io` is 0 in the same cycle that `hrst_pulse` is 1, whatever its value was before.
- R8: A write with `wr_en`=1, `wr_dword`=1 and `wr_offset`=MODE_OFS (default 10h) sets `dword_io` to 1 on the next cycle. A write with `wr_dword`=0, or to any other offset, leaves `dword_io` unchanged.
- R9: `ld_done` outside a pending load has no effect: no pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin | input | 1 | External hardware reset request, active high |
| pwr_good | input | 1 | Supply-valid indication that qualifies `rst_pin` |
| ld_done | input | 1 | EEPROM load finished (one-cycle strobe) |
| ld_crc_ok | input | 1 | CRC result, valid with `ld_done` |
| wr_en | input | 1 | Host register write strobe |
| wr_dword | input | 1 | Write is 32 bits wide (0 = 16-bit) |
| wr_offset | input | OFS_W | Host I/O offset of the write |
| hrst_pulse | output | 1 | One-cycle hardware reset event |
| eerst_pulse | output | 1 | One-cycle reset of EEPROM-programmable registers |
| ld_start | output | 1 | One-cycle request to begin the EEPROM read |
| dword_io | output | 1 | Bus width mode: 1 = 32-bit, 0 = 16-bit |

## Verification
On every cycle the assertions check that each reset output lasts one cycle, that a load request always comes straight after an EEPROM reset pulse, and that a hardware reset pulse appears only after MIN_PW qualified cycles. They also check that the mode bit is low alongside a hardware reset and rises only after a matching 32-bit write. Some behaviour shows only over a scenario, so the bench covers it: the exact pulse timing after a power-good glitch, the release-then-reset-then-load ordering, the extra EEPROM reset after a CRC failure, and the absence of any effect from short pulses, 16-bit writes and stray done strobes.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_ERST = 2'd2,
        SQ_LOAD = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic hw;
        logic ee;
        logic ld;
    } seq_pulse_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual
    import rstseq_pkg::*;
#(
    parameter int MIN_PW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    input  logic pwr_good,
    output logic hit_o
);
    localparam int CNT_W = cnt_width(MIN_PW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PW - 1);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(MIN_PW);

    logic             active;
    logic [CNT_W-1:0] run_cnt;

    assign active = rst_pin && pwr_good;
    assign hit_o  = active && (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!active) begin
            run_cnt <= '0;
        end else if (run_cnt != SAT) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       rst_pin,
    input  logic       ld_done,
    input  logic       ld_crc_ok,
    output seq_pulse_t pulses_o
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            pulses_o <= '0;
        end else begin
            pulses_o <= '0;
            if (hit) begin
                state       <= SQ_HOLD;
                pulses_o.hw <= 1'b1;
            end else begin
                case (state)
                    SQ_HOLD: begin
                        if (!rst_pin) begin
                            pulses_o.ee <= 1'b1;
                            state       <= SQ_ERST;
                        end
                    end
                    SQ_ERST: begin
                        pulses_o.ld <= 1'b1;
                        state       <= SQ_LOAD;
                    end
                    SQ_LOAD: begin
                        if (ld_done) begin
                            state       <= SQ_IDLE;
                            pulses_o.ee <= !ld_crc_ok;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rstseq_mode.sv
module rstseq_mode #(
    parameter int OFS_W    = 5,
    parameter int MODE_OFS = 'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             wr_en,
    input  logic             wr_dword,
    input  logic [OFS_W-1:0] wr_offset,
    output logic             dword_o
);
    localparam logic [OFS_W-1:0] SEL = OFS_W'(MODE_OFS);

    logic set_req;
    assign set_req = wr_en && wr_dword && (wr_offset == SEL);

    always_ff @(posedge clk) begin
        if (rst || hit) begin
            dword_o <= 1'b0;
        end else if (set_req) begin
            dword_o <= 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int MIN_PW   = 4,
    parameter int OFS_W    = 5,
    parameter int MODE_OFS = 'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_pin,
    input  logic             pwr_good,
    input  logic             ld_done,
    input  logic             ld_crc_ok,
    input  logic             wr_en,
    input  logic             wr_dword,
    input  logic [OFS_W-1:0] wr_offset,
    output logic             hrst_pulse,
    output logic             eerst_pulse,
    output logic             ld_start,
    output logic             dword_io
);
    logic       hit;
    seq_pulse_t pulses;

    rstseq_pin_qual #(.MIN_PW(MIN_PW)) u_qual (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .pwr_good(pwr_good), .hit_o(hit)
    );

    rstseq_fsm u_fsm (
        .clk(clk), .rst(rst), .hit(hit), .rst_pin(rst_pin),
        .ld_done(ld_done), .ld_crc_ok(ld_crc_ok), .pulses_o(pulses)
    );

    rstseq_mode #(.OFS_W(OFS_W), .MODE_OFS(MODE_OFS)) u_mode (
        .clk(clk), .rst(rst), .hit(hit), .wr_en(wr_en), .wr_dword(wr_dword),
        .wr_offset(wr_offset), .dword_o(dword_io)
    );

    assign hrst_pulse  = pulses.hw;
    assign eerst_pulse = pulses.ee;
    assign ld_start    = pulses.ld;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk #(
    parameter int MIN_PW   = 4,
    parameter int OFS_W    = 5,
    parameter int MODE_OFS = 'h10
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_pin,
    input logic             pwr_good,
    input logic             wr_en,
    input logic             wr_dword,
    input logic [OFS_W-1:0] wr_offset,
    input logic             hrst_pulse,
    input logic             eerst_pulse,
    input logic             ld_start,
    input logic             dword_io
);
    int  run_c;
    logic mode_wr;
    assign mode_wr = wr_en && wr_dword && (wr_offset == OFS_W'(MODE_OFS));

    always_ff @(posedge clk) begin
        if (rst || !(rst_pin && pwr_good)) run_c <= 0;
        else if (run_c < MIN_PW) run_c <= run_c + 1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !hrst_pulse && !eerst_pulse && !ld_start && !dword_io); // R1
    AST_HRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hrst_pulse |=> !hrst_pulse); // R2
    AST_HRST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        hrst_pulse |-> run_c >= MIN_PW); // R3
    AST_EE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        eerst_pulse |=> !eerst_pulse); // R5
    AST_LOAD_AFTER_EE: assert property (@(posedge clk) disable iff (rst)
        ld_start |-> $past(eerst_pulse) && !eerst_pulse); // R5
    AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        hrst_pulse |-> !dword_io); // R7
    AST_MODE_SET: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !(rst_pin && pwr_good)) |=> dword_io); // R8
    AST_MODE_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(dword_io) |-> $past(mode_wr)); // R8
endmodule

bind rstseq_ctrl rstseq_ctrl_chk #(
    .MIN_PW(MIN_PW), .OFS_W(OFS_W), .MODE_OFS(MODE_OFS)
) u_chk (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .pwr_good(pwr_good),
    .wr_en(wr_en), .wr_dword(wr_dword), .wr_offset(wr_offset),
    .hrst_pulse(hrst_pulse), .eerst_pulse(eerst_pulse),
    .ld_start(ld_start), .dword_io(dword_io)
);

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_PW     = 4;
    localparam int OFS_W      = 5;
    localparam int MODE_OFS   = 'h10;

    logic clk = 1'b0;
    logic rst, rst_pin, pwr_good, ld_done, ld_crc_ok, wr_en, wr_dword;
    logic [OFS_W-1:0] wr_offset;
    logic hrst_pulse, eerst_pulse, ld_start, dword_io;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstseq_ctrl #(.MIN_PW(MIN_PW), .OFS_W(OFS_W), .MODE_OFS(MODE_OFS)) u_dut (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .pwr_good(pwr_good),
        .ld_done(ld_done), .ld_crc_ok(ld_crc_ok), .wr_en(wr_en),
        .wr_dword(wr_dword), .wr_offset(wr_offset), .hrst_pulse(hrst_pulse),
        .eerst_pulse(eerst_pulse), .ld_start(ld_start), .dword_io(dword_io)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (hrst,eerst,ld,mode)", req, got, exp);
        end
    endtask

    function automatic logic [3:0] outs(input logic h, input logic e, input logic l, input logic m);
        return {h, e, l, m};
    endfunction

    function automatic logic is_mode_write(input logic en, input logic dw, input logic [OFS_W-1:0] ofs);
        return en && dw && (ofs == OFS_W'(MODE_OFS));
    endfunction

    task automatic idle_inputs();
        rst_pin = 0; pwr_good = 1; ld_done = 0; ld_crc_ok = 1;
        wr_en = 0; wr_dword = 0; wr_offset = '0;
    endtask

    task automatic mode_write(input logic dw, input logic [OFS_W-1:0] ofs);
        wr_en = 1; wr_dword = dw; wr_offset = ofs;
        tick();
        wr_en = 0;
    endtask

    // qualified hardware reset followed by release; leaves sequencer waiting for load
    task automatic hw_reset_and_release(input string req);
        rst_pin = 1;
        for (int i = 0; i < MIN_PW + 2; i++) begin
            tick();
            check(req, outs(hrst_pulse, eerst_pulse, ld_start, 1'b0),
                  outs(i == MIN_PW - 1, 1'b0, 1'b0, 1'b0));
        end
        rst_pin = 0;
        tick();
        check("R5", outs(hrst_pulse, eerst_pulse, ld_start, 1'b0), 4'b0100);
        tick();
        check("R5", outs(hrst_pulse, eerst_pulse, ld_start, 1'b0), 4'b0010);
        tick();
        check("R5", outs(hrst_pulse, eerst_pulse, ld_start, 1'b0), 4'b0000);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp_mode;
        int   run_m;
        process::self().srandom(32'h5EED_1234);
        idle_inputs();
        rst = 1;
        repeat (3) tick();
        check("R1 in reset", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        rst = 0;
        tick();
        check("R1 after reset", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);

        // R3: short pulse
        rst_pin = 1;
        for (int i = 0; i < MIN_PW - 1; i++) begin
            tick();
            check("R3 short", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end
        rst_pin = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R3 short after", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end
        // R3: long pulse without power good
        pwr_good = 0; rst_pin = 1;
        for (int i = 0; i < 3 * MIN_PW; i++) begin
            tick();
            check("R3 no pg", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end
        rst_pin = 0; pwr_good = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R3 no pg after", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end

        // R8: 16-bit write and wrong offset ignored, then dword write sets
        mode_write(1'b0, OFS_W'(MODE_OFS));
        check("R8 16-bit", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        mode_write(1'b1, OFS_W'(MODE_OFS + 4));
        check("R8 other ofs", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        mode_write(1'b1, OFS_W'(MODE_OFS));
        check("R8 set", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0001);

        // R4: power-good glitch restarts the count
        rst_pin = 1;
        for (int i = 0; i < 2; i++) begin
            tick();
            check("R4 pre", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0001);
        end
        pwr_good = 0;
        tick();
        check("R4 glitch", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0001);
        pwr_good = 1;
        for (int i = 0; i < MIN_PW + 1; i++) begin
            tick();
            if (i < MIN_PW - 1)
                check("R4 recount", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0001);
            else if (i == MIN_PW - 1)
                check("R7 clear", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b1000);
            else
                check("R2 no repeat", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end
        rst_pin = 0;
        tick();
        check("R5 ee", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0100);
        tick();
        check("R5 ld", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0010);
        // R6: load passes CRC
        tick();
        ld_done = 1; ld_crc_ok = 1;
        tick();
        ld_done = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 crc ok", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end

        // R2 timing + R6 CRC fail
        hw_reset_and_release("R2");
        ld_done = 1; ld_crc_ok = 0;
        tick();
        ld_done = 0; ld_crc_ok = 1;
        check("R6 crc fail", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0100);
        tick();
        check("R6 crc fail end", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);

        // R9: stray done in idle
        ld_done = 1; ld_crc_ok = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R9 stray done", outs(hrst_pulse, eerst_pulse, ld_start, dword_io), 4'b0000);
        end
        ld_done = 0; ld_crc_ok = 1;

        // Random: pin/pg and writes; check hrst and mode against bench model
        exp_mode = dword_io === 1'b1;
        run_m = 0;
        for (int i = 0; i < 3000; i++) begin
            logic hit_m;
            rst_pin   = ($urandom_range(0, 3) != 0) ? rst_pin : ~rst_pin;
            pwr_good  = ($urandom_range(0, 15) != 0);
            wr_en     = $urandom_range(0, 1);
            wr_dword  = $urandom_range(0, 1);
            wr_offset = ($urandom_range(0, 1) != 0) ? OFS_W'(MODE_OFS) : OFS_W'($urandom);
            hit_m = rst_pin && pwr_good && (run_m == MIN_PW - 1);
            if (!(rst_pin && pwr_good)) run_m = 0;
            else if (run_m < MIN_PW) run_m++;
            if (hit_m) exp_mode = 1'b0;
            else if (is_mode_write(wr_en, wr_dword, wr_offset)) exp_mode = 1'b1;
            tick();
            check("R2/R8 random", {hrst_pulse, 2'b00, dword_io}, {hit_m, 2'b00, exp_mode});
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule